// File: doc/BRIEF.md
# Polyphase Decimating FIR Filter

This block reduces the sample rate of a stream of signed real samples by an integer factor M. A single lowpass prototype of N taps, given as a parameter, is extended with trailing zero taps to the next multiple of M. It is then split into M sub-filters of L = ceil(N/M) taps each. A commutator hands each accepted sample to the next slot in rotation. For that sample, L multiplies are done against the slot's own coefficient set and its own history of earlier samples. The partial sum is added into an accumulator that restarts at every output period. After the M-th accepted sample of a period, the block emits one rounded and saturated output.

Upstream logic presents a sample with a one-cycle valid strobe. Samples may arrive in every cycle or with gaps of any length. Downstream logic receives a one-cycle valid strobe with each decimated result. Each output equals the full N-tap convolution of the prototype with the most recent N accepted inputs. Inputs that precede reset count as zero.

Top module: `polyphase_decim`

## Requirements
- R1: Accepted samples are assigned to slots 0, 1, ..., M-1 in rotation. The slot advances only when a sample is accepted, and the first sample after reset takes slot 0.
- R2: With accepted samples numbered x[0], x[1], ... since reset, the output for period m is the sum over k = 0..N-1 of h[k]·x[mM+M-1-k]. Samples with negative index count as zero, and the sum is carried at full precision before rounding.
- R3: Prototype positions N through L·M-1 (the padding) contribute nothing. An impulse that has aged by N or more accepted samples leaves a zero output.
- R4: out_valid is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the M-th sample of a period, and out_valid is low at every other time.
- R5: The full-precision sum S is rounded half toward positive infinity before the shift: out = floor((S + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT). For example, 1.5 becomes 2 and -1.5 becomes -1.
- R6: A rounded value above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit on out_data, in two's complement.
- R7: When in_valid is low, in_data is ignored. The slot, the accumulator and the history are left unchanged, and no output is produced.
- R8: While rst_n is low at a clock edge, the history is cleared, the slot returns to 0 and out_valid and out_data go to 0. The next output then follows M fresh accepted samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for each decimated output |
| out_data | output | OUT_W | Signed rounded and saturated output |

## Verification
The bench builds the block with M = 4 and a 10-tap prototype. The prototype is therefore padded by two zero taps, giving three taps per slot, and the padding, the wrap of the slot and the carry of history across periods all show up within a few dozen samples. The bench uses 12-bit data, 10-bit coefficients, a 12-bit output and a shift of 8. With these widths, an impulse of 128 lands exactly on half-LSB cases for the odd coefficients, and a run of full-scale samples drives the result past both saturation limits. Random samples with random gaps of garbage data, and a reset in the middle of a period, check that alignment and history survive idle cycles and are cleared by reset.

// File: rtl/pdf_pkg.sv
// Shared constants and helpers for the polyphase decimator.
// Assumes the coefficient vector never needs more than COEF_BITS_MAX bits.
package pdf_pkg;

    localparam int COEF_BITS_MAX = 4096;

    // Builds a triangular lowpass prototype, packed tap 0 at the LSBs.
    function automatic logic [COEF_BITS_MAX-1:0] tri_window(int ntaps, int cw);
        logic [COEF_BITS_MAX-1:0] v;
        logic [31:0] w;
        int mag;
        v = '0;
        for (int k = 0; k < ntaps; k++) begin
            mag = ((k + 1) < (ntaps - k)) ? (k + 1) : (ntaps - k);
            w = 32'(mag * 64);
            for (int b = 0; b < cw; b++) begin
                v[k*cw + b] = w[b];
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/pdf_commutator.sv
// Input commutator: tracks which slot of the output period the next
// accepted sample occupies. Assumes DECIM >= 2.
module pdf_commutator #(
    parameter int DECIM  = 20,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic              first,
    output logic              last
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DECIM - 1);

    assign first = (slot == '0);
    assign last  = (slot == LAST_SLOT);

    // Rotate through the slots, one step per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (adv) begin
            slot <= last ? '0 : slot + 1'b1;
        end
    end

endmodule

// File: rtl/pdf_phase_bank.sv
// Per-slot sample history. Row tap 0 is the arriving sample, and tap t
// is the sample that occupied the same slot t periods ago.
// Assumes slot < DECIM. With one tap per slot no storage is built.
module pdf_phase_bank #(
    parameter int DECIM  = 20,
    parameter int DATA_W = 16,
    parameter int TAPS   = 3,
    parameter int SLOT_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [DATA_W-1:0]            din,
    output logic [TAPS-1:0][DATA_W-1:0]  row
);

    localparam int HIST = TAPS - 1;

    generate
        if (HIST > 0) begin : g_hist
            logic [DATA_W-1:0] mem [DECIM][HIST];

            // Shift the selected slot's history by one on each accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < DECIM; s++) begin
                        for (int t = 0; t < HIST; t++) begin
                            mem[s][t] <= '0;
                        end
                    end
                end else if (wr) begin
                    mem[slot][0] <= din;
                    for (int t = 1; t < HIST; t++) begin
                        mem[slot][t] <= mem[slot][t-1];
                    end
                end
            end

            // Present the arriving sample followed by the slot's history.
            always_comb begin
                row[0] = din;
                for (int t = 1; t < TAPS; t++) begin
                    row[t] = mem[slot][t-1];
                end
            end
        end else begin : g_nohist
            // Single-tap slots need only the arriving sample.
            always_comb begin
                row[0] = din;
            end
        end
    endgenerate

endmodule

// File: rtl/pdf_phase_mac.sv
// Multiplies one slot's sample row with that slot's sub-filter and sums
// the products. The slot in position q uses prototype taps j*DECIM +
// (DECIM-1-q). Positions at or beyond NTAPS read as zero (padding).
module pdf_phase_mac import pdf_pkg::*; #(
    parameter int DECIM  = 20,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 3,
    parameter int NTAPS  = 45,
    parameter int ACC_W  = 38,
    parameter int SLOT_W = 5,
    parameter logic [COEF_BITS_MAX-1:0] COEF_VEC = '0
) (
    input  logic [SLOT_W-1:0]            slot,
    input  logic [TAPS-1:0][DATA_W-1:0]  row,
    output logic signed [ACC_W-1:0]      partial
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];

    generate
        for (genvar j = 0; j < TAPS; j++) begin : g_tap
            int                 idx;
            logic [COEF_W-1:0]  coef;

            // Pick this tap's coefficient for the current slot.
            always_comb begin
                idx  = j * DECIM + (DECIM - 1 - int'(slot));
                coef = (idx < NTAPS) ? COEF_VEC[idx*COEF_W +: COEF_W] : '0;
            end

            // Full-precision signed product.
            assign prod[j] = PROD_W'($signed(row[j])) * PROD_W'($signed(coef));
        end
    endgenerate

    // Sum the products of the row.
    always_comb begin
        partial = '0;
        for (int j = 0; j < TAPS; j++) begin
            partial = partial + ACC_W'(prod[j]);
        end
    end

endmodule

// File: rtl/pdf_round_sat.sv
// Rounds half toward +inf, drops SHIFT LSBs and clamps to OUT_W signed.
// Assumes ACC_W >= OUT_W.
module pdf_round_sat #(
    parameter int ACC_W = 38,
    parameter int OUT_W = 16,
    parameter int SHIFT = 15
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        out
);

    localparam logic signed [ACC_W:0] MAXV =
        $signed({{(ACC_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [ACC_W:0] MINV = ~MAXV;

    logic signed [ACC_W:0] ext;
    logic signed [ACC_W:0] shifted;

    generate
        if (SHIFT > 0) begin : g_round
            localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (SHIFT - 1);
            // Add half an output LSB, then shift arithmetically.
            always_comb begin
                ext     = {acc[ACC_W-1], acc} + HALF;
                shifted = ext >>> SHIFT;
            end
        end else begin : g_noround
            // No fractional bits to drop.
            always_comb begin
                ext     = {acc[ACC_W-1], acc};
                shifted = ext;
            end
        end
    endgenerate

    // Clamp to the output range.
    always_comb begin
        if (shifted > MAXV) begin
            out = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            out = MINV[OUT_W-1:0];
        end else begin
            out = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/polyphase_decim.sv
// Polyphase decimating FIR. Each accepted sample costs one row of
// ceil(NTAPS/DECIM) multiplies, and the sum of one period gives one output
// in the cycle after the period's last sample is accepted.
// Assumes DECIM >= 2 and NTAPS*COEF_W <= COEF_BITS_MAX.
module polyphase_decim import pdf_pkg::*; #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int OUT_W     = 16,
    parameter int DECIM     = 20,
    parameter int NTAPS     = 45,
    parameter int OUT_SHIFT = 15,
    parameter logic [COEF_BITS_MAX-1:0] COEF_VEC = tri_window(NTAPS, COEF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    localparam int TAPS   = (NTAPS + DECIM - 1) / DECIM;
    localparam int SLOT_W = $clog2(DECIM);
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS);

    logic [SLOT_W-1:0]           slot_q;
    logic                        first_slot;
    logic                        last_slot;
    logic [TAPS-1:0][DATA_W-1:0] row;
    logic signed [ACC_W-1:0]     partial;
    logic signed [ACC_W-1:0]     acc_q;
    logic signed [ACC_W-1:0]     acc_next;
    logic [OUT_W-1:0]            rs_out;

    pdf_commutator #(
        .DECIM  (DECIM),
        .SLOT_W (SLOT_W)
    ) u_comm (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .slot  (slot_q),
        .first (first_slot),
        .last  (last_slot)
    );

    pdf_phase_bank #(
        .DECIM  (DECIM),
        .DATA_W (DATA_W),
        .TAPS   (TAPS),
        .SLOT_W (SLOT_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (in_valid),
        .slot  (slot_q),
        .din   (in_data),
        .row   (row)
    );

    pdf_phase_mac #(
        .DECIM    (DECIM),
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .TAPS     (TAPS),
        .NTAPS    (NTAPS),
        .ACC_W    (ACC_W),
        .SLOT_W   (SLOT_W),
        .COEF_VEC (COEF_VEC)
    ) u_mac (
        .slot    (slot_q),
        .row     (row),
        .partial (partial)
    );

    // Restart the sum at the first slot of a period.
    assign acc_next = (first_slot ? '0 : acc_q) + partial;

    pdf_round_sat #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .SHIFT (OUT_SHIFT)
    ) u_rs (
        .acc (acc_next),
        .out (rs_out)
    );

    // Hold the running period sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (in_valid) begin
            acc_q <= acc_next;
        end
    end

    // Register the finished output and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid && last_slot;
            if (in_valid && last_slot) begin
                out_data <= rs_out;
            end
        end
    end

endmodule

// File: rtl/pdf_checker.sv
// Temporal checks on the polyphase decimator, attached through bind.
// Keeps its own count of accepted samples to judge slot and output timing.
module pdf_checker #(
    parameter int DECIM  = 20,
    parameter int SLOT_W = 5,
    parameter int ACC_W  = 38
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic [SLOT_W-1:0]       slot,
    input logic signed [ACC_W-1:0] acc
);

    int   cnt_q;
    logic fire_q;
    logic was_rst_q;

    // Independent count of accepted samples within the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= 0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= in_valid && (cnt_q == DECIM - 1);
            if (in_valid) begin
                cnt_q <= (cnt_q == DECIM - 1) ? 0 : cnt_q + 1;
            end
        end
    end

    // Remember whether the previous edge was in reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    AST_SLOT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot) == cnt_q); // R1
    AST_OUT_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == fire_q); // R4
    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(slot) && $stable(acc) && !out_valid)); // R7
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (slot == '0 && !out_valid)); // R8

endmodule

bind polyphase_decim pdf_checker #(
    .DECIM  (DECIM),
    .SLOT_W (SLOT_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .slot      (slot_q),
    .acc       (acc_q)
);

// File: tb/sim_polyphase_decim.sv
`timescale 1ns/1ps
module sim_polyphase_decim;

    localparam int DW = 12;
    localparam int CW = 10;
    localparam int OW = 12;
    localparam int M  = 4;
    localparam int N  = 10;
    localparam int SH = 8;

    typedef struct {
        int    val;
        int    cyc;
        string tag;
    } exp_t;

    // Bench prototype: 10 symmetric taps, sum 372.
    function automatic int coef(int k);
        case (k)
            0, 9: return 3;
            1, 8: return -7;
            2, 7: return 20;
            3, 6: return 60;
            4, 5: return 110;
            default: return 0;
        endcase
    endfunction

    function automatic logic [pdf_pkg::COEF_BITS_MAX-1:0] pack_h();
        logic [pdf_pkg::COEF_BITS_MAX-1:0] v;
        logic [31:0] w;
        v = '0;
        for (int k = 0; k < N; k++) begin
            w = 32'(coef(k));
            for (int b = 0; b < CW; b++) v[k*CW + b] = w[b];
        end
        return v;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t sb[$];
    int   hist[$];
    logic [31:0] lf = 32'h1bad_c0de;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    polyphase_decim #(
        .DATA_W(DW), .COEF_W(CW), .OUT_W(OW), .DECIM(M), .NTAPS(N),
        .OUT_SHIFT(SH), .COEF_VEC(pack_h())
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void step_lfsr();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
    endfunction

    // Reference model: full N-tap convolution, round half up, clamp.
    task automatic model_accept(int x, string tag);
        longint acc;
        longint r;
        int n;
        hist.push_back(x);
        if (hist.size() % M == 0) begin
            n = hist.size() - 1;
            acc = 0;
            for (int k = 0; k < N; k++) begin
                if (n - k >= 0) acc += longint'(coef(k)) * longint'(hist[n-k]);
            end
            r = (acc + (longint'(1) << (SH - 1))) >>> SH;
            if (r > (2**(OW-1) - 1)) r = 2**(OW-1) - 1;
            if (r < -(2**(OW-1))) r = -(2**(OW-1));
            sb.push_back('{val: int'(r), cyc: cyc + 1, tag: tag});
        end
    endtask

    // Driver: present one accepted sample and record its expectations.
    task automatic send(int x, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x[DW-1:0];
        model_accept(x, tag);
    endtask

    // Idle cycles with garbage on in_data (R7).
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_lfsr();
            in_valid = 1'b0;
            in_data  = lf[DW-1:0];
        end
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        idle(1);
        while (sb.size() != 0 && guard < 50) begin
            idle(1);
            guard++;
        end
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
        hist.delete();
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each produced output.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "unexpected out_valid", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(int'($signed(out_data)) == e.val, e.tag, "out_data",
                        int'($signed(out_data)), e.val);
                    chk(cyc == e.cyc, "R4", "output cycle", cyc, e.cyc);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        // R8: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(out_data == '0, "R8", "out_data after reset", int'(out_data), 0);

        // R2/R3/R5: positive impulse of 128 gives half-LSB cases and pad taps.
        send(128, "R5_pos_impulse");
        for (int i = 0; i < 15; i++) send(0, "R3_pad_tail");
        drain();

        // R5: negative impulse, -1.5 must round to -1.
        send(-128, "R5_neg_impulse");
        for (int i = 0; i < 11; i++) send(0, "R5_neg_tail");
        drain();

        // R2/R7: random samples with random gaps of garbage data.
        for (int i = 0; i < 48; i++) begin
            step_lfsr();
            v = int'($signed(lf[DW-1:0]));
            send(v, "R2_r7_gaps");
            if (lf[20]) idle(1 + int'(lf[22:21]));
        end
        drain();

        // R6: full-scale runs saturate both ways.
        for (int i = 0; i < 12; i++) send(2047, "R6_pos_sat");
        for (int i = 0; i < 12; i++) send(-2048, "R6_neg_sat");
        drain();

        // R1/R8: reset in mid-period, then alignment restarts at slot 0.
        send(500, "R8_pre");
        send(-300, "R8_pre");
        do_reset(2);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after mid reset", int'(out_valid), 0);
        for (int i = 0; i < 12; i++) send((i == 1) ? 256 : 0, "R1_realign");
        drain();

        chk(sb.size() == 0, "R4", "outputs left unmatched", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule